// File: doc/BRIEF.md
# Buffered SPI Master with Transmit Gate

This block is a memory-mapped SPI master for byte-wide traffic. Software loads bytes into a transmit queue, and a shift engine sends each byte on MOSI while it captures one byte from MISO into a receive queue. A gate bit in the control word stops new bytes from starting. Software sets the gate, fills the queue, and then clears the gate so that the whole batch goes out without a software step between bytes. A one-cycle event pulse goes to an interrupt block when the queue has drained and the last byte has left the wire.

The serial clock rate is fixed when the block is built (`HALF_DIV` system clocks per SCK half-period), so no register can change it. The control word selects the SCK idle level and the sampling edge, which gives the four usual SPI modes. It also flushes either queue and chooses how the slave selects are driven. In manual mode the selects follow a register at all times. In automatic mode the selects follow that register only while a byte is in flight.

The register port has four word addresses: 0 control, 1 status, 2 data (a write queues a byte, a read takes one), 3 slave select.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status reads 0x05 (bit0 receive empty, bit2 transmit empty), the control word reads 0, the select register reads all ones, every ss_n line is high and SCK is low.
- R2: While control bit8 (gate) is set, SCK does not toggle and the queued bytes stay queued. Clearing bit8 sends every queued byte.
- R3: The transmit queue holds FIFO_DEPTH bytes. Status bit3 is set when it is full, and a data write to a full queue is dropped.
- R4: Each byte sent pushes exactly one received byte. A received byte that arrives while the receive queue is full is dropped. Status bit1 is receive full. A data read from an empty receive queue returns 0 and removes nothing.
- R5: Control bit3 (CPOL) sets the SCK idle level. With control bit4 (CPHA) at 0, MISO is sampled on the first edge of each bit; with bit4 at 1, on the second. Bytes go out MSB first.
- R6: Control bits 5 and 6 flush the transmit and receive queue respectively on the write cycle, and always read back as 0.
- R7: With control bit7 set, ss_n equals the select register at all times. With bit7 clear, ss_n equals that register only while a byte is in flight, and is all ones otherwise.
- R8: tx_empty_evt pulses once, for one cycle, when a byte has finished shifting and the transmit queue is empty.
- R9: When bit1 (enable) and bit2 (master) are set and ss_in_n is low, status bit4 (mode fault) sets and the hardware clears bit1. Reading the status clears bit4.
- R10: No byte starts unless both control bit1 and bit2 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 2) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SEL | Active-low slave selects |
| ss_in_n | input | 1 | Active-low select from another master (mode fault source) |
| tx_empty_evt | output | 1 | One-cycle pulse: queue drained and last byte done |

## Verification
Most wrong internal states in this block show up on the serial pins or in the receive queue within one byte time (about 36 system clocks). If the sampling edge is wrong, or the bit order is shifted, a slave model clocked by SCK captures the wrong byte, and the inverted echo read back from the receive queue is also wrong. A wrong queue pointer or a missed flush shows up later, at the next status read or data read, as a wrong count of bytes or a wrong order. A gate or enable that leaks shows up as SCK edges while the block should be idle.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_SEL  = 2'd3;

  localparam int CB_EN     = 1;
  localparam int CB_MASTER = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CPHA   = 4;
  localparam int CB_TXRST  = 5;
  localparam int CB_RXRST  = 6;
  localparam int CB_MANUAL = 7;
  localparam int CB_GATE   = 8;

  localparam logic [8:0] CTRL_KEEP = 9'h19E;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_HOLD} eng_state_t;

  function automatic logic sample_on_edge(input logic cpha, input logic [3:0] edge_idx);
    return edge_idx[0] == cpha;
  endfunction

  function automatic logic [15:0] pack_status(input logic rx_empty, input logic rx_full,
                                              input logic tx_empty, input logic tx_full,
                                              input logic fault);
    return {11'd0, fault, tx_full, tx_empty, rx_full, rx_empty};
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wp, rp, count;
  logic push_ok, pop_ok;

  assign count   = wp - rp;
  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  output logic       busy
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  eng_state_t state;
  logic [DW-1:0] div_cnt;
  logic [3:0] edge_idx;
  logic [7:0] txsr, rxsr;
  logic sck_q, mosi_q;
  logic tick;

  assign tick    = (div_cnt == DIV_LAST);
  assign tx_pop  = (state == ENG_IDLE) && go && tx_valid;
  assign rx_push = (state == ENG_HOLD) && tick;
  assign rx_byte = rxsr;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign busy    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      div_cnt  <= '0;
      edge_idx <= '0;
      txsr     <= '0;
      rxsr     <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          sck_q    <= cpol;
          div_cnt  <= '0;
          edge_idx <= '0;
          if (go && tx_valid) begin
            state <= ENG_SHIFT;
            if (!cpha) begin
              mosi_q <= tx_byte[7];
              txsr   <= {tx_byte[6:0], 1'b0};
            end else begin
              txsr   <= tx_byte;
            end
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            div_cnt  <= '0;
            sck_q    <= ~sck_q;
            edge_idx <= edge_idx + 4'd1;
            if (sample_on_edge(cpha, edge_idx)) begin
              rxsr <= {rxsr[6:0], miso};
            end else begin
              mosi_q <= txsr[7];
              txsr   <= {txsr[6:0], 1'b0};
            end
            if (edge_idx == 4'd15) state <= ENG_HOLD;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        ENG_HOLD: begin
          if (tick) begin
            div_cnt <= '0;
            state   <= ENG_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SEL    = 4,
  parameter int HALF_DIV   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] ss_n,
  input  logic               ss_in_n,
  output logic               tx_empty_evt
);
  logic [8:0] ctrl_q;
  logic [NUM_SEL-1:0] sel_q;
  logic fault_q, evt_q;
  logic [1:0] ss_sync;

  logic wr_ctrl, wr_data, wr_sel, rd_data, rd_stat;
  logic tx_flush, rx_flush, tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_head, rx_head, rx_byte;
  logic tx_pop, rx_push, busy, go, fault_set;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_sel  = reg_wr && (reg_addr == ADDR_SEL);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);

  assign tx_flush = wr_ctrl && reg_wdata[CB_TXRST];
  assign rx_flush = wr_ctrl && reg_wdata[CB_RXRST];

  assign go        = ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ctrl_q[CB_GATE];
  assign fault_set = ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ss_sync[1];

  spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_data), .din(reg_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_byte),
    .pop(rd_data), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spim_shifter #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
    .tx_valid(!tx_empty), .tx_byte(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .busy(busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '1;
      fault_q <= 1'b0;
      evt_q   <= 1'b0;
      ss_sync <= 2'b11;
    end else begin
      ss_sync <= {ss_sync[0], ss_in_n};
      if (wr_ctrl) ctrl_q <= reg_wdata[8:0] & CTRL_KEEP;
      if (fault_set) ctrl_q[CB_EN] <= 1'b0;
      if (wr_sel) sel_q <= reg_wdata[NUM_SEL-1:0];
      if (fault_set)    fault_q <= 1'b1;
      else if (rd_stat) fault_q <= 1'b0;
      evt_q <= rx_push && tx_empty;
    end
  end

  assign tx_empty_evt = evt_q;
  assign ss_n = (ctrl_q[CB_MANUAL] || busy) ? sel_q : '1;

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {7'd0, ctrl_q};
      ADDR_STAT: reg_rdata = pack_status(rx_empty, rx_full, tx_empty, tx_full, fault_q);
      ADDR_DATA: reg_rdata = rx_empty ? 16'd0 : {8'd0, rx_head};
      default:   reg_rdata = {{(16-NUM_SEL){1'b0}}, sel_q};
    endcase
  end

  p_fault_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> !ctrl_q[CB_EN]);

  p_evt_only_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !tx_empty) |=> !tx_empty_evt);

  p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |=> !tx_empty_evt);

endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic sck, mosi, miso, ss_in_n = 1, tx_empty_evt;
  logic [3:0] ss_n;

  int n_cmp = 0, n_bad = 0, evt_cnt = 0, sck_edges = 0, cap_bits = 0;
  logic bcpol = 0, bcpha = 0;
  logic [7:0] cap = 0;
  logic [7:0] capq[$];
  logic [7:0] sent[$];

  assign miso = ~mosi;

  spi_fifo_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .ss_in_n(ss_in_n), .tx_empty_evt(tx_empty_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (tx_empty_evt) evt_cnt++;
  always @(posedge sck or negedge sck) sck_edges++;

  task automatic take_bit();
    cap = {cap[6:0], mosi};
    cap_bits++;
    if (cap_bits == 8) begin
      capq.push_back(cap);
      cap_bits = 0;
    end
  endtask

  always @(posedge sck) if (!ss_n[0] && (bcpol == bcpha)) take_bit();
  always @(negedge sck) if (!ss_n[0] && (bcpol != bcpha)) take_bit();

  function automatic logic [15:0] ctrl_word(bit en, bit mst, bit cpol, bit cpha, bit man, bit gate);
    return 16'((int'(en) << 1) | (int'(mst) << 2) | (int'(cpol) << 3) |
               (int'(cpha) << 4) | (int'(man) << 7) | (int'(gate) << 8));
  endfunction

  function automatic logic [7:0] echo_of(logic [7:0] b);
    return ~b;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_evt(string tag);
    int start = evt_cnt;
    for (int i = 0; i < 5000 && evt_cnt == start; i++) @(negedge clk);
    check(tag, int'(evt_cnt != start), 1);
  endtask

  task automatic drain_check(string tag, int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      rd(2'd2, d);
      check({tag, " R4 echo"}, int'(d), int'(echo_of(sent[i])));
      if (i < capq.size()) check({tag, " R5 wire"}, int'(capq[i]), int'(sent[i]));
    end
    check({tag, " R5 count"}, capq.size(), n);
  endtask

  task automatic run_mode(bit cpol, bit cpha, int n);
    logic [15:0] d;
    int e0;
    bcpol = cpol; bcpha = cpha;
    wr(2'd0, ctrl_word(1, 1, cpol, cpha, 0, 1));
    idle(3);
    check("R5 idle level", int'(sck), int'(cpol));
    check("R7 auto idle", int'(ss_n), 4'hF);
    capq.delete(); sent.delete(); cap_bits = 0;
    for (int i = 0; i < n; i++) begin
      sent.push_back(8'($urandom));
      wr(2'd2, {8'd0, sent[i]});
    end
    e0 = evt_cnt;
    wr(2'd0, ctrl_word(1, 1, cpol, cpha, 0, 0));
    idle(4);
    check("R7 auto busy", int'(ss_n), 4'hE);
    wait_evt("R8 event");
    idle(40);
    check("R8 one pulse", evt_cnt - e0, 1);
    rd(2'd1, d);
    check("R4 status", int'(d), 16'h0004);
    drain_check("mode", n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t0, e0;
    void'($urandom(32'd24680));
    idle(5);
    rst_n = 1;
    idle(2);

    rd(2'd1, d); check("R1 status", int'(d), 16'h0005);
    rd(2'd0, d); check("R1 ctrl", int'(d), 0);
    rd(2'd3, d); check("R1 sel", int'(d), 16'h000F);
    check("R1 ss_n", int'(ss_n), 4'hF);
    check("R1 sck", int'(sck), 0);
    rd(2'd2, d); check("R4 empty read", int'(d), 0);

    wr(2'd3, 16'h000E);
    bcpol = 0; bcpha = 0;
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 1));
    capq.delete(); sent.delete(); cap_bits = 0;
    sent.push_back(8'hA5); sent.push_back(8'h3C); sent.push_back(8'h0F);
    foreach (sent[i]) wr(2'd2, {8'd0, sent[i]});
    t0 = sck_edges;
    idle(100);
    check("R2 gate holds", sck_edges - t0, 0);
    rd(2'd1, d); check("R2 queued", int'(d), 16'h0001);
    wr(2'd0, ctrl_word(0, 1, 0, 0, 0, 0));
    idle(100);
    check("R10 no enable", sck_edges - t0, 0);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 0));
    wait_evt("R2 release");
    check("R2 edges", sck_edges - t0, 48);
    drain_check("R2", 3);

    for (int m = 0; m < 4; m++) run_mode(m[1], m[0], 1 + int'($urandom % 5));

    // R3: fill past depth, extra write dropped; then R4 receive overflow
    bcpol = 0; bcpha = 0;
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 1));
    capq.delete(); sent.delete(); cap_bits = 0;
    for (int i = 0; i <= DEPTH; i++) begin
      sent.push_back(8'($urandom));
      wr(2'd2, {8'd0, sent[i]});
    end
    rd(2'd1, d); check("R3 full flag", int'(d), 16'h0009);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 0));
    wait_evt("R3 drain");
    rd(2'd1, d); check("R4 rx full", int'(d), 16'h0006);
    wr(2'd2, 16'h0011);
    wr(2'd2, 16'h0022);
    wait_evt("R4 extra sent");
    check("R3 dropped byte", capq.size(), DEPTH + 2);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd2, d);
      check("R4 kept order", int'(d), int'(echo_of(sent[i])));
    end
    rd(2'd2, d); check("R4 empty zero", int'(d), 0);
    rd(2'd1, d); check("R4 empty status", int'(d), 16'h0005);

    // R6 flushes
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 1));
    wr(2'd2, 16'h0055); wr(2'd2, 16'h0066);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 1) | 16'h0020);
    rd(2'd0, d); check("R6 self clear", int'(d), int'(ctrl_word(1, 1, 0, 0, 0, 1)));
    rd(2'd1, d); check("R6 tx flushed", int'(d), 16'h0005);
    t0 = sck_edges; e0 = evt_cnt;
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 0));
    idle(100);
    check("R6 nothing sent", sck_edges - t0, 0);
    check("R6 no event", evt_cnt - e0, 0);
    wr(2'd2, 16'h0077);
    wait_evt("R6 rx fill");
    rd(2'd1, d); check("R6 rx has data", int'(d), 16'h0004);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 0) | 16'h0040);
    rd(2'd1, d); check("R6 rx flushed", int'(d), 16'h0005);

    // R7 manual selects
    wr(2'd0, ctrl_word(1, 1, 0, 0, 1, 0));
    wr(2'd3, 16'h000B);
    idle(1);
    check("R7 manual", int'(ss_n), 4'hB);
    wr(2'd3, 16'h000F);
    idle(1);
    check("R7 manual off", int'(ss_n), 4'hF);

    // R9 mode fault
    wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 0));
    ss_in_n = 0;
    idle(5);
    ss_in_n = 1;
    idle(5);
    rd(2'd1, d); check("R9 fault flag", int'(d), 16'h0015);
    rd(2'd0, d); check("R9 enable cleared", int'(d), int'(ctrl_word(0, 1, 0, 0, 0, 0)));
    rd(2'd1, d); check("R9 read clears", int'(d), 16'h0005);

    summary();
    $finish;
  end
endmodule